// File: doc/BRIEF.md
# AXI Write Upsizer, 32-bit to 64-bit

This block sits between a 32-bit AXI write master and a 64-bit AXI write slave. It takes one INCR write burst at a time on its narrow side and reissues it on its wide side. Each narrow beat is steered into the correct half of the 64-bit data bus by address bit 2. Strobes follow the data, and data bytes whose strobe is low are driven as zero.

When packing is allowed, consecutive narrow beats that fall in the same 8-byte block are folded into one wide beat, and the wide burst is issued with a 64-bit beat size. Packing is allowed when the modifiable cache bit (bit 1) is set and the `cfg_no_merge` input is low. When packing is not allowed, every narrow beat becomes its own wide beat and the beat size is kept.

The wide side never carries more than `MAX_BURST` beats per burst, so a long request is cut into several downstream bursts. In that case the lock marking is dropped and all the downstream responses are folded into a single upstream response.

Control is a five-state machine:
- `ST_IDLE` accepts a request and goes to `ST_ADDR`.
- `ST_ADDR` issues one downstream address and goes to `ST_DATA` when it is taken.
- `ST_DATA` streams wide beats and goes to `ST_RESP` on the burst's last wide beat.
- `ST_RESP` takes one downstream response. It goes back to `ST_ADDR` if wide beats remain, otherwise to `ST_REPLY`.
- `ST_REPLY` presents the folded response and returns to `ST_IDLE` when it is taken.

Top module: `axi_upsizer_wr`

## Requirements
- R1: After reset the block is idle: `s_awready` is high and `m_awvalid`, `m_wvalid`, `s_bvalid` and `s_wready` are low.
- R2: With packing allowed (`s_awcache[1]`=1 and `cfg_no_merge`=0), `m_awsize` is 3. The total wide beat count is the number of 8-byte blocks touched by the bytes from the size-aligned start address through the burst's end. Each downstream `m_awlen` is that burst's beat count minus one.
- R3: A narrow beat goes to wide byte lanes 4..7 when its address bit 2 is 1, otherwise to lanes 0..3. Strobes of packed beats are OR-combined. Lanes never written keep strobe 0 and data 0.
- R4: In packing mode a wide beat is emitted when the next narrow beat's address lies in another 8-byte block, or with the beat carrying `s_wlast`.
- R5: With `s_awcache[1]`=0, each narrow beat yields exactly one wide beat, and `m_awsize` equals `s_awsize`.
- R6: With `cfg_no_merge`=1, the block behaves as in R5 whatever the cache bits are.
- R7: No downstream burst exceeds `MAX_BURST` (default 16) wide beats. Each burst's `m_awaddr` is the address of its first narrow beat. `m_wlast` marks each burst's final beat.
- R8: `m_awlock` copies `s_awlock` only when the request needs one downstream burst, and is 0 when it is split.
- R9: Response codes are OKAY=2'b00, EXOKAY=2'b01, SLVERR=2'b10, DECERR=2'b11. For an unsplit request the single downstream code is returned unchanged, EXOKAY included.
- R10: For a split request the returned code is the worst downstream code by DECERR over SLVERR over OKAY. EXOKAY counts as OKAY and is never returned.
- R11: Once a request is accepted, `s_awready` stays low. `s_bvalid` rises only after every downstream response has been taken.
- R12: `s_wready` is high only while a downstream burst is open. A narrow beat that completes a wide beat is accepted only together with that wide beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_no_merge | input | 1 | Forbids packing; sampled when a request is accepted |
| s_awvalid | input | 1 | Narrow address valid |
| s_awready | output | 1 | Narrow address ready |
| s_awaddr | input | ADDR_W | Narrow start address |
| s_awlen | input | LEN_W | Narrow beats minus one |
| s_awsize | input | 3 | Narrow beat size code |
| s_awcache | input | 4 | Cache attributes; bit 1 permits packing |
| s_awlock | input | 1 | Exclusive marking |
| s_wvalid | input | 1 | Narrow data valid |
| s_wready | output | 1 | Narrow data ready |
| s_wdata | input | NARROW_W | Narrow write data |
| s_wstrb | input | NARROW_W/8 | Narrow byte strobes |
| s_wlast | input | 1 | Last narrow beat |
| s_bvalid | output | 1 | Upstream response valid |
| s_bready | input | 1 | Upstream response ready |
| s_bresp | output | 2 | Folded response code |
| m_awvalid | output | 1 | Wide address valid |
| m_awready | input | 1 | Wide address ready |
| m_awaddr | output | ADDR_W | Wide burst start address |
| m_awlen | output | LEN_W | Wide beats minus one |
| m_awsize | output | 3 | Wide beat size code |
| m_awburst | output | 2 | Burst type, always INCR (2'b01) |
| m_awcache | output | 4 | Cache attributes passed through |
| m_awlock | output | 1 | Exclusive marking when not split |
| m_wvalid | output | 1 | Wide data valid |
| m_wready | input | 1 | Wide data ready |
| m_wdata | output | WIDE_W | Wide write data |
| m_wstrb | output | WIDE_W/8 | Wide byte strobes |
| m_wlast | output | 1 | Last beat of current wide burst |
| m_bvalid | input | 1 | Downstream response valid |
| m_bready | output | 1 | Downstream response ready |
| m_bresp | input | 2 | Downstream response code |

## Verification
Two events can coincide in one cycle: the flush of a packed wide beat on an 8-byte boundary, and the end of a downstream burst at its `MAX_BURST`-th beat. That beat must then carry merged strobes and `m_wlast` together, and the next `m_awaddr` must start at the following block. The bench provokes this with packed and unpacked requests longer than `MAX_BURST` wide beats, while the wide data and address readies stall in repeating patterns. It predicts every wide beat, every downstream address and the folded response from a byte-address model, and compares them in the order they appear.

// File: rtl/axi_up_pkg.sv
package axi_up_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_DATA  = 3'd2,
        ST_RESP  = 3'd3,
        ST_REPLY = 3'd4
    } up_state_e;

    localparam logic [1:0] RESP_OKAY   = 2'b00;
    localparam logic [1:0] RESP_EXOKAY = 2'b01;
    localparam logic [1:0] RESP_SLVERR = 2'b10;
    localparam logic [1:0] RESP_DECERR = 2'b11;

    localparam logic [1:0] BURST_INCR  = 2'b01;

    // Map EXOKAY onto OKAY; the remaining codes then order by severity numerically.
    function automatic logic [1:0] resp_norm(input logic [1:0] code);
        return (code == RESP_EXOKAY) ? RESP_OKAY : code;
    endfunction

    function automatic logic [1:0] resp_worst(input logic [1:0] a, input logic [1:0] b);
        logic [1:0] na;
        logic [1:0] nb;
        na = resp_norm(a);
        nb = resp_norm(b);
        return (na > nb) ? na : nb;
    endfunction

endpackage

// File: rtl/axi_up_beatcalc.sv
module axi_up_beatcalc #(
    parameter int ADDR_W  = 32,
    parameter int LEN_W   = 8,
    parameter int WIDE_W  = 64
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    input  logic [2:0]        size,
    input  logic              pack,
    output logic [LEN_W:0]    beats
);
    localparam int WB  = WIDE_W / 8;
    localparam int WSH = $clog2(WB);
    localparam int CNT_W = LEN_W + 1;

    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] aligned;
    logic [ADDR_W-1:0] total_bytes;
    logic [ADDR_W-1:0] end_byte;
    logic [ADDR_W-1:0] blk_first;
    logic [ADDR_W-1:0] blk_last;
    logic [ADDR_W-1:0] blk_span;

    always_comb begin
        step        = ADDR_W'(1) << size;
        aligned     = addr & ~(step - ADDR_W'(1));
        total_bytes = (ADDR_W'(len) + ADDR_W'(1)) << size;
        end_byte    = aligned + total_bytes - ADDR_W'(1);
        blk_first   = aligned >> WSH;
        blk_last    = end_byte >> WSH;
        blk_span    = blk_last - blk_first + ADDR_W'(1);
        if (pack) begin
            beats = CNT_W'(blk_span);
        end else begin
            beats = CNT_W'(len) + CNT_W'(1);
        end
    end

endmodule

// File: rtl/axi_up_packer.sv
module axi_up_packer #(
    parameter int NARROW_W = 32,
    parameter int WIDE_W   = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    take,
    input  logic                    flush,
    input  logic [$clog2(WIDE_W/NARROW_W)-1:0] lane_sel,
    input  logic [NARROW_W-1:0]     n_data,
    input  logic [NARROW_W/8-1:0]   n_strb,
    output logic [WIDE_W-1:0]       w_data,
    output logic [WIDE_W/8-1:0]     w_strb
);
    localparam int NB   = NARROW_W / 8;
    localparam int WB   = WIDE_W / 8;
    localparam int SEGS = WB / NB;

    logic [NARROW_W-1:0] n_clean;
    logic [WIDE_W-1:0]   placed_data;
    logic [WB-1:0]       placed_strb;
    logic [WIDE_W-1:0]   hold_data;
    logic [WB-1:0]       hold_strb;

    // Zero every byte whose strobe is low.
    for (genvar b = 0; b < NB; b++) begin : g_mask
        assign n_clean[b*8 +: 8] = n_strb[b] ? n_data[b*8 +: 8] : 8'h00;
    end

    // Steer the cleaned narrow beat into its address-selected segment.
    for (genvar k = 0; k < SEGS; k++) begin : g_seg
        assign placed_data[k*NARROW_W +: NARROW_W] = (lane_sel == k) ? n_clean : '0;
        assign placed_strb[k*NB +: NB]             = (lane_sel == k) ? n_strb  : '0;
    end

    assign w_data = hold_data | placed_data;
    assign w_strb = hold_strb | placed_strb;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            hold_data <= '0;
            hold_strb <= '0;
        end else if (take) begin
            if (flush) begin
                hold_data <= '0;
                hold_strb <= '0;
            end else begin
                hold_data <= w_data;
                hold_strb <= w_strb;
            end
        end
    end

endmodule

// File: rtl/axi_up_respfold.sv
module axi_up_respfold
    import axi_up_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       take,
    input  logic       split,
    input  logic [1:0] resp_in,
    output logic [1:0] resp_out
);
    logic [1:0] fold_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            fold_q <= RESP_OKAY;
        end else if (take) begin
            if (split) begin
                fold_q <= resp_worst(fold_q, resp_in);
            end else begin
                fold_q <= resp_in;
            end
        end
    end

    assign resp_out = fold_q;

    AST_NO_EXOKAY_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        split |-> (resp_out != RESP_EXOKAY)); // R10

endmodule

// File: rtl/axi_upsizer_wr.sv
module axi_upsizer_wr
    import axi_up_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 8,
    parameter int NARROW_W  = 32,
    parameter int WIDE_W    = 64,
    parameter int MAX_BURST = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_no_merge,
    input  logic                  s_awvalid,
    output logic                  s_awready,
    input  logic [ADDR_W-1:0]     s_awaddr,
    input  logic [LEN_W-1:0]      s_awlen,
    input  logic [2:0]            s_awsize,
    input  logic [3:0]            s_awcache,
    input  logic                  s_awlock,
    input  logic                  s_wvalid,
    output logic                  s_wready,
    input  logic [NARROW_W-1:0]   s_wdata,
    input  logic [NARROW_W/8-1:0] s_wstrb,
    input  logic                  s_wlast,
    output logic                  s_bvalid,
    input  logic                  s_bready,
    output logic [1:0]            s_bresp,
    output logic                  m_awvalid,
    input  logic                  m_awready,
    output logic [ADDR_W-1:0]     m_awaddr,
    output logic [LEN_W-1:0]      m_awlen,
    output logic [2:0]            m_awsize,
    output logic [1:0]            m_awburst,
    output logic [3:0]            m_awcache,
    output logic                  m_awlock,
    output logic                  m_wvalid,
    input  logic                  m_wready,
    output logic [WIDE_W-1:0]     m_wdata,
    output logic [WIDE_W/8-1:0]   m_wstrb,
    output logic                  m_wlast,
    input  logic                  m_bvalid,
    output logic                  m_bready,
    input  logic [1:0]            m_bresp
);
    localparam int NB    = NARROW_W / 8;
    localparam int WB    = WIDE_W / 8;
    localparam int NSH   = $clog2(NB);
    localparam int WSH   = $clog2(WB);
    localparam int CNT_W = LEN_W + 1;
    localparam logic [CNT_W-1:0] MAX_CNT  = CNT_W'(MAX_BURST);
    localparam logic [2:0]       WIDE_SZ  = 3'(WSH);

    up_state_e state_q;
    up_state_e state_d;

    logic [ADDR_W-1:0] cur_addr_q;
    logic [2:0]        size_q;
    logic [3:0]        cache_q;
    logic              lock_q;
    logic              pack_q;
    logic              split_q;
    logic [CNT_W-1:0]  remain_q;
    logic [CNT_W-1:0]  chunk_q;

    logic              pack_now;
    logic [CNT_W-1:0]  req_beats;
    logic [CNT_W-1:0]  chunk_beats;
    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] next_addr;
    logic              flush;

    logic              aw_in_hs;
    logic              aw_out_hs;
    logic              w_in_hs;
    logic              w_out_hs;
    logic              b_out_hs;

    assign pack_now = !cfg_no_merge && s_awcache[1];

    axi_up_beatcalc #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .WIDE_W (WIDE_W)
    ) u_calc (
        .addr  (s_awaddr),
        .len   (s_awlen),
        .size  (s_awsize),
        .pack  (pack_now),
        .beats (req_beats)
    );

    assign chunk_beats = (remain_q > MAX_CNT) ? MAX_CNT : remain_q;

    always_comb begin
        step      = ADDR_W'(1) << size_q;
        next_addr = (cur_addr_q & ~(step - ADDR_W'(1))) + step;
        flush     = !pack_q || s_wlast ||
                    (next_addr[ADDR_W-1:WSH] != cur_addr_q[ADDR_W-1:WSH]);
    end

    assign aw_in_hs  = s_awvalid && s_awready;
    assign aw_out_hs = m_awvalid && m_awready;
    assign w_in_hs   = s_wvalid && s_wready;
    assign w_out_hs  = m_wvalid && m_wready;
    assign b_out_hs  = m_bvalid && m_bready;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (s_awvalid) state_d = ST_ADDR;
            ST_ADDR:  if (m_awready) state_d = ST_DATA;
            ST_DATA:  if (w_out_hs && chunk_q == CNT_W'(1)) state_d = ST_RESP;
            ST_RESP:  if (m_bvalid) state_d = (remain_q == '0) ? ST_REPLY : ST_ADDR;
            ST_REPLY: if (s_bready) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Handshake outputs
    always_comb begin
        s_awready = 1'b0;
        m_awvalid = 1'b0;
        s_wready  = 1'b0;
        m_wvalid  = 1'b0;
        m_bready  = 1'b0;
        s_bvalid  = 1'b0;
        unique case (state_q)
            ST_IDLE:  s_awready = 1'b1;
            ST_ADDR:  m_awvalid = 1'b1;
            ST_DATA: begin
                s_wready = !flush || m_wready;
                m_wvalid = s_wvalid && flush;
            end
            ST_RESP:  m_bready = 1'b1;
            ST_REPLY: s_bvalid = 1'b1;
            default: ;
        endcase
    end

    // Request context and beat counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr_q <= '0;
            size_q     <= '0;
            cache_q    <= '0;
            lock_q     <= 1'b0;
            pack_q     <= 1'b0;
            split_q    <= 1'b0;
            remain_q   <= '0;
            chunk_q    <= '0;
        end else begin
            if (aw_in_hs) begin
                cur_addr_q <= s_awaddr;
                size_q     <= s_awsize;
                cache_q    <= s_awcache;
                lock_q     <= s_awlock;
                pack_q     <= pack_now;
                split_q    <= (req_beats > MAX_CNT);
                remain_q   <= req_beats;
            end
            if (aw_out_hs) begin
                chunk_q <= chunk_beats;
            end
            if (w_in_hs) begin
                cur_addr_q <= next_addr;
            end
            if (w_out_hs) begin
                chunk_q  <= chunk_q - CNT_W'(1);
                remain_q <= remain_q - CNT_W'(1);
            end
        end
    end

    assign m_awaddr  = cur_addr_q;
    assign m_awlen   = LEN_W'(chunk_beats - CNT_W'(1));
    assign m_awsize  = pack_q ? WIDE_SZ : size_q;
    assign m_awburst = BURST_INCR;
    assign m_awcache = cache_q;
    assign m_awlock  = lock_q && !split_q;
    assign m_wlast   = (chunk_q == CNT_W'(1));

    axi_up_packer #(
        .NARROW_W (NARROW_W),
        .WIDE_W   (WIDE_W)
    ) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (aw_in_hs),
        .take     (w_in_hs),
        .flush    (flush),
        .lane_sel (cur_addr_q[WSH-1:NSH]),
        .n_data   (s_wdata),
        .n_strb   (s_wstrb),
        .w_data   (m_wdata),
        .w_strb   (m_wstrb)
    );

    axi_up_respfold u_resp (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (aw_in_hs),
        .take     (b_out_hs),
        .split    (split_q),
        .resp_in  (m_bresp),
        .resp_out (s_bresp)
    );

    AST_AW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        m_awvalid && !m_awready |=> m_awvalid && $stable(m_awaddr)); // R7
    AST_BEAT_WITHIN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        m_wvalid |-> remain_q != '0); // R7
    AST_FINAL_BEAT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        m_wvalid && m_wlast && remain_q == CNT_W'(1) |-> s_wlast); // R7
    AST_LOCK_ONE_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        m_awvalid && m_awlock |-> remain_q <= MAX_CNT); // R8
    AST_REPLY_AFTER_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        s_bvalid |-> remain_q == '0); // R11
    AST_UNPACKED_ONE_SEG: assert property (@(posedge clk) disable iff (!rst_n)
        m_wvalid && !pack_q |-> $countones(m_wstrb) <= NB); // R5

endmodule

// File: tb/tb_axi_upsizer_wr.sv
module tb_axi_upsizer_wr;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n;
    logic        cfg_no_merge;
    logic        s_awvalid, s_awready;
    logic [31:0] s_awaddr;
    logic [7:0]  s_awlen;
    logic [2:0]  s_awsize;
    logic [3:0]  s_awcache;
    logic        s_awlock;
    logic        s_wvalid, s_wready;
    logic [31:0] s_wdata;
    logic [3:0]  s_wstrb;
    logic        s_wlast;
    logic        s_bvalid, s_bready;
    logic [1:0]  s_bresp;
    logic        m_awvalid, m_awready;
    logic [31:0] m_awaddr;
    logic [7:0]  m_awlen;
    logic [2:0]  m_awsize;
    logic [1:0]  m_awburst;
    logic [3:0]  m_awcache;
    logic        m_awlock;
    logic        m_wvalid, m_wready;
    logic [63:0] m_wdata;
    logic [7:0]  m_wstrb;
    logic        m_wlast;
    logic        m_bvalid, m_bready;
    logic [1:0]  m_bresp;

    axi_upsizer_wr dut (
        .clk(clk), .rst_n(rst_n), .cfg_no_merge(cfg_no_merge),
        .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr),
        .s_awlen(s_awlen), .s_awsize(s_awsize), .s_awcache(s_awcache), .s_awlock(s_awlock),
        .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wstrb(s_wstrb),
        .s_wlast(s_wlast), .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
        .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr), .m_awlen(m_awlen),
        .m_awsize(m_awsize), .m_awburst(m_awburst), .m_awcache(m_awcache), .m_awlock(m_awlock),
        .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata), .m_wstrb(m_wstrb),
        .m_wlast(m_wlast), .m_bvalid(m_bvalid), .m_bready(m_bready), .m_bresp(m_bresp)
    );

    localparam int MAXB = 16;

    typedef struct packed {
        logic [31:0] addr;
        logic [7:0]  len;
        logic [2:0]  size;
        logic        lock;
    } aw_exp_t;

    typedef struct packed {
        logic [63:0] data;
        logic [7:0]  strb;
        logic        last;
    } w_exp_t;

    aw_exp_t    aw_q[$];
    w_exp_t     w_q[$];
    logic [1:0] b_q[$];
    logic [1:0] plan_q[$];

    int    total = 0;
    int    bad   = 0;
    int    w_seen = 0;
    int    cyc = 0;
    string cur_tag = "R1";

    aw_exp_t ea;
    w_exp_t  ew;
    logic [1:0] eb;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] worst2(input logic [1:0] a, input logic [1:0] b);
        logic [1:0] na;
        logic [1:0] nb;
        na = (a == 2'b01) ? 2'b00 : a;
        nb = (b == 2'b01) ? 2'b00 : b;
        return (na > nb) ? na : nb;
    endfunction

    // Slave-side ready patterns, changed just after the rising edge.
    initial begin
        m_awready = 1'b1;
        m_wready  = 1'b1;
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            m_awready = (cyc % 3) != 0;
            m_wready  = (cyc % 4) != 1;
        end
    end

    // Downstream response model: one response per closed wide burst.
    initial begin
        m_bvalid = 1'b0;
        m_bresp  = 2'b00;
        forever begin
            @(negedge clk);
            if (rst_n && m_wvalid && m_wready && m_wlast) begin
                @(posedge clk);
                #1;
                m_bvalid = 1'b1;
                m_bresp  = (plan_q.size() != 0) ? plan_q.pop_front() : 2'b00;
                do @(negedge clk); while (!m_bready);
                @(posedge clk);
                #1;
                m_bvalid = 1'b0;
            end
        end
    end

    // Monitor: compare handshakes against the scoreboard queues mid-cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            if (m_awvalid && m_awready) begin
                if (aw_q.size() == 0) begin
                    check(1'b0, "R7", "unexpected downstream address", 64'(m_awaddr), 64'h0);
                end else begin
                    ea = aw_q.pop_front();
                    check(m_awaddr == ea.addr, "R7", "awaddr", 64'(m_awaddr), 64'(ea.addr));
                    check(m_awlen == ea.len, "R2", "awlen", 64'(m_awlen), 64'(ea.len));
                    check(m_awsize == ea.size, "R2", "awsize", 64'(m_awsize), 64'(ea.size));
                    check(m_awlock == ea.lock, "R8", "awlock", 64'(m_awlock), 64'(ea.lock));
                end
            end
            if (m_wvalid && m_wready) begin
                w_seen++;
                if (w_q.size() == 0) begin
                    check(1'b0, "R4", "unexpected wide beat", m_wdata, 64'h0);
                end else begin
                    ew = w_q.pop_front();
                    check(m_wdata == ew.data, "R3", "wdata", m_wdata, ew.data);
                    check(m_wstrb == ew.strb, "R3", "wstrb", 64'(m_wstrb), 64'(ew.strb));
                    check(m_wlast == ew.last, "R7", "wlast", 64'(m_wlast), 64'(ew.last));
                end
            end
            if (s_bvalid && s_bready) begin
                check(plan_q.size() == 0, "R11", "reply before all responses",
                      64'(plan_q.size()), 64'h0);
                if (b_q.size() == 0) begin
                    check(1'b0, cur_tag, "unexpected reply", 64'(s_bresp), 64'h0);
                end else begin
                    eb = b_q.pop_front();
                    check(s_bresp == eb, cur_tag, "bresp", 64'(s_bresp), 64'(eb));
                end
            end
        end
    end

    task automatic run_txn(input string tag, input logic [31:0] addr, input int len,
                           input int size, input logic [3:0] cache, input logic lock,
                           input logic nomerge, input logic [7:0] rsp, input int seed);
        logic        pack;
        int          n;
        logic [31:0] al;
        logic [31:0] a;
        logic [31:0] nxt;
        logic [31:0] nd[$];
        logic [3:0]  ns[$];
        logic [63:0] wd[$];
        logic [7:0]  ws[$];
        logic [31:0] wa[$];
        logic [63:0] accd;
        logic [7:0]  accs;
        logic [31:0] d;
        logic [31:0] dm;
        logic [3:0]  s4;
        logic [31:0] first_a;
        bit          have;
        bit          fl;
        int          nb;
        int          nchunks;
        logic [1:0]  expb;

        cur_tag = tag;
        pack = !nomerge && cache[1];
        n  = 1 << size;
        al = addr & ~(n - 1);
        accd = '0; accs = '0; have = 0; first_a = '0;
        for (int i = 0; i <= len; i++) begin
            a = (i == 0) ? addr : al + 32'(i * n);
            d = 32'hC3000000 ^ (32'(seed) << 12) ^ (32'(i) * 32'h01030507);
            s4 = '0;
            dm = '0;
            for (int b = 0; b < 4; b++) begin
                logic [31:0] ba;
                ba = (a & ~32'h3) + 32'(b);
                if (ba >= a && ba < (a & ~32'(n - 1)) + 32'(n)) begin
                    s4[b] = 1'b1;
                    dm[b*8 +: 8] = d[b*8 +: 8];
                end
            end
            nd.push_back(d);
            ns.push_back(s4);
            if (!have) first_a = a;
            have = 1;
            if (a[2]) begin
                accd[63:32] = accd[63:32] | dm;
                accs[7:4]   = accs[7:4] | s4;
            end else begin
                accd[31:0]  = accd[31:0] | dm;
                accs[3:0]   = accs[3:0] | s4;
            end
            nxt = al + 32'((i + 1) * n);
            fl = !pack || (i == len) || ((nxt >> 3) != (a >> 3));
            if (fl) begin
                wd.push_back(accd);
                ws.push_back(accs);
                wa.push_back(first_a);
                accd = '0; accs = '0; have = 0;
            end
        end
        nb = wd.size();
        nchunks = (nb + MAXB - 1) / MAXB;
        for (int c = 0; c < nchunks; c++) begin
            aw_exp_t x;
            int      cnt;
            cnt = (nb - c * MAXB > MAXB) ? MAXB : nb - c * MAXB;
            x.addr = wa[c * MAXB];
            x.len  = 8'(cnt - 1);
            x.size = pack ? 3'd3 : 3'(size);
            x.lock = lock && (nchunks == 1);
            aw_q.push_back(x);
            plan_q.push_back(rsp[2*c +: 2]);
        end
        for (int k = 0; k < nb; k++) begin
            w_exp_t y;
            y.data = wd[k];
            y.strb = ws[k];
            y.last = ((k % MAXB) == MAXB - 1) || (k == nb - 1);
            w_q.push_back(y);
        end
        if (nchunks == 1) begin
            expb = rsp[1:0];
        end else begin
            expb = 2'b00;
            for (int c = 0; c < nchunks; c++) expb = worst2(expb, rsp[2*c +: 2]);
        end
        b_q.push_back(expb);
        w_seen = 0;

        cfg_no_merge = nomerge;
        s_awaddr  = addr;
        s_awlen   = 8'(len);
        s_awsize  = 3'(size);
        s_awcache = cache;
        s_awlock  = lock;
        s_awvalid = 1'b1;
        do @(negedge clk); while (!s_awready);
        @(posedge clk);
        #1;
        s_awvalid = 1'b0;
        @(negedge clk);
        check(!s_awready, "R11", "awready while busy", 64'(s_awready), 64'h0);
        @(posedge clk);
        #1;
        for (int i = 0; i <= len; i++) begin
            s_wvalid = 1'b1;
            s_wdata  = nd[i];
            s_wstrb  = ns[i];
            s_wlast  = (i == len);
            do @(negedge clk); while (!s_wready);
            @(posedge clk);
            #1;
        end
        s_wvalid = 1'b0;
        s_wlast  = 1'b0;
        while (b_q.size() != 0) @(posedge clk);
        #1;
        check(w_seen == nb, tag, "wide beat count", 64'(w_seen), 64'(nb));
        check(aw_q.size() == 0 && w_q.size() == 0, tag, "leftover expectations",
              64'(aw_q.size() + w_q.size()), 64'h0);
    endtask

    initial begin
        #(200000 * 10);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        cfg_no_merge = 1'b0;
        s_awvalid = 1'b0; s_awaddr = '0; s_awlen = '0; s_awsize = '0;
        s_awcache = '0; s_awlock = 1'b0;
        s_wvalid = 1'b0; s_wdata = '0; s_wstrb = '0; s_wlast = 1'b0;
        s_bready = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        check(s_awready == 1'b1, "R1", "awready after reset", 64'(s_awready), 64'h1);
        check(!m_awvalid && !m_wvalid && !s_bvalid, "R1", "valids after reset",
              {61'h0, m_awvalid, m_wvalid, s_bvalid}, 64'h0);
        check(!s_wready, "R12", "wready outside data phase", 64'(s_wready), 64'h0);
        @(posedge clk);
        #1;

        // R2: 2-byte beats packed four to one wide beat
        run_txn("R2", 32'h0000_0100, 3, 1, 4'b0011, 1'b0, 1'b0, 8'h00, 1);
        // R4: byte beats crossing an 8-byte boundary from an unaligned start
        run_txn("R4", 32'h0000_0203, 7, 0, 4'b0010, 1'b0, 1'b0, 8'h02, 2);
        // R3: start in the upper half of a wide word
        run_txn("R3", 32'h0000_0104, 2, 1, 4'b0010, 1'b0, 1'b0, 8'h00, 3);
        // R3: full-width narrow beats, first lands in lanes 4..7
        run_txn("R3", 32'h0000_1004, 7, 2, 4'b1111, 1'b0, 1'b0, 8'h00, 4);
        // R5: noncacheable, no packing
        run_txn("R5", 32'h0000_0300, 3, 1, 4'b0000, 1'b0, 1'b0, 8'h00, 5);
        // R6: bypass forces no packing on a cacheable request
        run_txn("R6", 32'h0000_0400, 3, 1, 4'b0011, 1'b0, 1'b1, 8'h00, 6);
        // R8: packed split into two bursts, lock stripped, SLVERR folded in
        run_txn("R8", 32'h0000_2000, 63, 2, 4'b0011, 1'b1, 1'b0, 8'b0000_1000, 7);
        // R10: unpacked split into three bursts: SLVERR, DECERR, EXOKAY -> DECERR
        run_txn("R10", 32'h0000_0400, 39, 2, 4'b0000, 1'b0, 1'b0, 8'b0001_1110, 8);
        // R9: unsplit exclusive keeps lock and EXOKAY
        run_txn("R9", 32'h0000_0500, 3, 2, 4'b0011, 1'b1, 1'b0, 8'b0000_0001, 9);
        // R10: split with only EXOKAY answers -> OKAY
        run_txn("R10", 32'h0000_0600, 39, 2, 4'b0000, 1'b1, 1'b0, 8'b0001_0101, 10);
        // R7: packed byte beats exceed one burst, flush and burst end coincide
        run_txn("R7", 32'h0000_3000, 255, 0, 4'b0010, 1'b0, 1'b0, 8'b1011_0000, 11);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule